// File: doc/BRIEF.md
# Signed Arithmetic Unit with Range Trap

This block is a 16-bit arithmetic unit for two's-complement operands only. It adds, subtracts and multiplies two signed operands and registers a 16-bit signed result. Every operation also registers two range indications. One is raised when the true result is above the largest representable value. The other is raised when the true result is below the smallest representable value.

A small processor uses the block as its only arithmetic engine. Any out-of-range result is treated as fatal. A sticky halt flag is therefore set whenever either range indication is raised, and only reset clears it. Add and subtract use a one-bit sign extension and inspect the two top bits of the extended result. Multiply forms the full double-width product and tests whether it fits in 16 bits. Timing of the detection path is not critical, because a trap stops the machine.

Top module: `signed_alu_trap`

## Requirements
- R1: With `op` = 2'b00 and `valid` high at a rising edge, `result` shows the low 16 bits of `opnd_a + opnd_b` after that edge. `ovf_pos` is 1 exactly when the true sum is above +32767, and `ovf_neg` is 1 exactly when it is below -32768.
- R2: With `op` = 2'b01 and `valid` high, `result` shows the low 16 bits of `opnd_a - opnd_b`, with the same above/below range flags for the true difference.
- R3: With `op` = 2'b10 and `valid` high, `result` shows the low 16 bits of the full 32-bit signed product. `ovf_pos` is 1 when the product is above +32767 and `ovf_neg` is 1 when it is below -32768. The product -32768 × 1 raises neither flag.
- R4: `ovf_pos` and `ovf_neg` are never high together. Both are rewritten on every valid operation, so an in-range operation clears them.
- R5: `halt_err` becomes 1 after any valid operation that raises either range flag. It then stays 1 until `rst`.
- R6: With `op` = 2'b11 and `valid` high, `result` keeps its value, both range flags go low and `halt_err` is unchanged.
- R7: While `valid` is low, `result`, `ovf_pos`, `ovf_neg` and `halt_err` hold their values, whatever the operands and opcode are.
- R8: A synchronous active-high `rst` clears `result`, `ovf_pos`, `ovf_neg` and `halt_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Starts an operation at this edge |
| op | input | 2 | 00 add, 01 subtract, 10 multiply, 11 reserved |
| opnd_a | input | 16 | Signed first operand (minuend for subtract) |
| opnd_b | input | 16 | Signed second operand (subtrahend for subtract) |
| result | output | 16 | Registered signed result, low 16 bits of the true value |
| ovf_pos | output | 1 | Last operation's result was above +32767 |
| ovf_neg | output | 1 | Last operation's result was below -32768 |
| halt_err | output | 1 | Sticky trap flag, cleared only by reset |

## Verification
The bench targets the values at the edge of the range. These are 32767 + 1 and -32768 + -1, which a design that only compares carry bits would misclassify. They also include 0 - (-32768), which a design that negates the subtrahend within 16 bits would miss, because the negation wraps back to -32768. For multiply, the bench checks -32768 × -1, which a design that only watches the product's sign bit would pass as in range. It also checks -32768 × 1, which an off-by-one range compare would wrongly flag. Further checks confirm that a clean operation clears the range flags but not the halt flag, and that the reserved opcode and idle cycles leave the result untouched.

// File: rtl/salu_pkg.sv
package salu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_RSV = 2'b11
  } salu_op_e;
endpackage

// File: rtl/salu_addsub.sv
// Add or subtract at one extra bit of width; the two top bits of the
// extended value give the range class (01 above, 10 below).
module salu_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] value,
  output logic              above,
  output logic              below
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [EXT_W-1:0] ext_rhs;
  logic [EXT_W-1:0] ext_sum;

  always_comb begin
    ext_a   = {a[DATA_W-1], a};
    ext_b   = {b[DATA_W-1], b};
    ext_rhs = sub ? (~ext_b + EXT_W'(1)) : ext_b;
    ext_sum = ext_a + ext_rhs;
    value   = ext_sum[DATA_W-1:0];
    above   = (ext_sum[EXT_W-1:DATA_W-1] == 2'b01);
    below   = (ext_sum[EXT_W-1:DATA_W-1] == 2'b10);
  end
endmodule

// File: rtl/salu_mul.sv
// Full double-width signed product; in range only when every bit above
// the result's sign bit equals the product's sign.
module salu_mul #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] value,
  output logic              above,
  output logic              below
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] wide_a;
  logic signed [PROD_W-1:0] wide_b;
  logic signed [PROD_W-1:0] prod;
  logic [PROD_W-DATA_W:0]   upper;

  always_comb begin
    wide_a = {{DATA_W{a[DATA_W-1]}}, a};
    wide_b = {{DATA_W{b[DATA_W-1]}}, b};
    prod   = wide_a * wide_b;
    upper  = prod[PROD_W-1:DATA_W-1];
    value  = prod[DATA_W-1:0];
    above  = !upper[PROD_W-DATA_W] && (|upper);
    below  = upper[PROD_W-DATA_W] && !(&upper);
  end
endmodule

// File: rtl/salu_trap.sv
// Sticky halt flag: set by any range event, cleared only by reset.
module salu_trap (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  output logic halt
);
  always_ff @(posedge clk) begin
    if (rst) halt <= 1'b0;
    else if (set_evt) halt <= 1'b1;
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
endmodule

// File: rtl/signed_alu_trap.sv
module signed_alu_trap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              ovf_pos,
  output logic              ovf_neg,
  output logic              halt_err
);
  import salu_pkg::*;

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  salu_op_e          op_e;
  logic [DATA_W-1:0] as_val;
  logic              as_above;
  logic              as_below;
  logic [DATA_W-1:0] mul_val;
  logic              mul_above;
  logic              mul_below;
  logic [DATA_W-1:0] nxt_val;
  logic              nxt_above;
  logic              nxt_below;
  logic              nxt_load;

  assign op_e = salu_op_e'(op);

  salu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a     (opnd_a),
    .b     (opnd_b),
    .sub   (op_e == OP_SUB),
    .value (as_val),
    .above (as_above),
    .below (as_below)
  );

  salu_mul #(.DATA_W(DATA_W)) u_mul (
    .a     (opnd_a),
    .b     (opnd_b),
    .value (mul_val),
    .above (mul_above),
    .below (mul_below)
  );

  always_comb begin
    nxt_val   = result;
    nxt_above = 1'b0;
    nxt_below = 1'b0;
    nxt_load  = 1'b0;
    case (op_e)
      OP_ADD, OP_SUB: begin
        nxt_val   = as_val;
        nxt_above = as_above;
        nxt_below = as_below;
        nxt_load  = 1'b1;
      end
      OP_MUL: begin
        nxt_val   = mul_val;
        nxt_above = mul_above;
        nxt_below = mul_below;
        nxt_load  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      ovf_pos <= 1'b0;
      ovf_neg <= 1'b0;
    end else if (valid) begin
      if (nxt_load) result <= nxt_val;
      ovf_pos <= nxt_above;
      ovf_neg <= nxt_below;
    end
  end

  salu_trap u_trap (
    .clk     (clk),
    .rst     (rst),
    .set_evt (valid && (nxt_above || nxt_below)),
    .halt    (halt_err)
  );

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ovf_pos && ovf_neg));

  // R5
  flag_implies_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_pos || ovf_neg) |-> halt_err);

  // R6
  reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 2'b11) |=> ($stable(result) && !ovf_pos && !ovf_neg
                                && $stable(halt_err)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(result) && $stable(ovf_pos) && $stable(ovf_neg)
                && $stable(halt_err)));

  // R3
  mul_min_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 2'b10 && opnd_a == MOST_NEG && opnd_b == ONE)
      |=> (!ovf_pos && !ovf_neg && result == MOST_NEG));

  // R1
  add_sign_rule_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && op == 2'b00 && !opnd_a[DATA_W-1] && !opnd_b[DATA_W-1])
      |=> (ovf_pos == result[DATA_W-1] && !ovf_neg));
endmodule

// File: tb/tb_signed_alu_trap.sv
`timescale 1ns/1ps
module tb_signed_alu_trap;
  localparam int W  = 16;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] result;
  logic ovf_pos, ovf_neg, halt_err;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] m_res = '0;
  logic m_pos = 1'b0, m_neg = 1'b0, m_err = 1'b0;

  always #2.5 clk = ~clk;

  signed_alu_trap #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .valid(valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .ovf_pos(ovf_pos), .ovf_neg(ovf_neg),
    .halt_err(halt_err)
  );

  localparam logic [1:0] V_OP [NV] = '{
    2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01,
    2'b01, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10};
  localparam logic [W-1:0] V_A [NV] = '{
    16'd100, 16'h7FFF, 16'h8000, 16'hFFFB, 16'd7, 16'd0, 16'h8000,
    16'h8000, 16'h8000, 16'h8000, 16'd200, 16'd181, 16'd256};
  localparam logic [W-1:0] V_B [NV] = '{
    16'd23, 16'd1, 16'hFFFF, 16'd3, 16'd3, 16'h8000, 16'd1,
    16'h8000, 16'hFFFF, 16'd1, 16'd200, 16'hFF4B, 16'hFF38};

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model from the requirements: true value in int, range compare.
  task automatic model(input logic [1:0] o, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    int sa, sb, t;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (o == 2'b11) begin
      m_pos = 1'b0;
      m_neg = 1'b0;
    end else begin
      t = (o == 2'b00) ? sa + sb : (o == 2'b01) ? sa - sb : sa * sb;
      m_res = t[W-1:0];
      m_pos = (t > 32767);
      m_neg = (t < -32768);
      m_err = m_err | m_pos | m_neg;
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b);
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    model(o, a, b);
  endtask

  task automatic check_all(input string req);
    chk(req, "result", int'(result), int'(m_res));
    chk(req, "ovf_pos", int'(ovf_pos), int'(m_pos));
    chk(req, "ovf_neg", int'(ovf_neg), int'(m_neg));
    chk(req, "halt_err", int'(halt_err), int'(m_err));
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R8");

    // Vector table: R1 add, R2 subtract, R3 multiply; flags rewritten (R4).
    for (int i = 0; i < NV; i++) begin
      run_op(V_OP[i], V_A[i], V_B[i]);
      case (V_OP[i])
        2'b00:   check_all("R1");
        2'b01:   check_all("R2");
        default: check_all("R3");
      endcase
      chk("R4", "flags exclusive", int'(ovf_pos & ovf_neg), 0);
    end

    // R3 corner: -32768 x 1 gives no flag
    run_op(2'b10, 16'h8000, 16'd1);
    chk("R3", "min x 1 pos", int'(ovf_pos), 0);
    chk("R3", "min x 1 neg", int'(ovf_neg), 0);
    chk("R3", "min x 1 res", int'(result), 32'h8000);

    // R4 and R5: an overflow then a clean op clears flags, halt stays
    run_op(2'b00, 16'h7FFF, 16'd1);
    chk("R4", "ovf_pos set", int'(ovf_pos), 1);
    run_op(2'b01, 16'd10, 16'd4);
    chk("R4", "ovf_pos cleared", int'(ovf_pos), 0);
    chk("R5", "halt sticky", int'(halt_err), 1);
    chk("R2", "10-4", int'(result), 6);

    // R6: reserved opcode after a flagging op
    run_op(2'b10, 16'd256, 16'hFF38);
    chk("R3", "unf set", int'(ovf_neg), 1);
    run_op(2'b11, 16'd1, 16'd2);
    chk("R6", "result held", int'(result), 16'd14336);
    chk("R6", "ovf_neg low", int'(ovf_neg), 0);
    chk("R6", "halt held", int'(halt_err), 1);

    // R7: idle cycles with changing inputs
    @(negedge clk);
    op = 2'b00; opnd_a = 16'h7FFF; opnd_b = 16'h7FFF;
    repeat (3) @(negedge clk);
    opnd_a = 16'd5;
    @(negedge clk);
    chk("R7", "result held", int'(result), 16'd14336);
    chk("R7", "ovf_pos held", int'(ovf_pos), 0);
    chk("R7", "halt held", int'(halt_err), 1);

    // R8: reset clears sticky halt
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_res = '0; m_pos = 1'b0; m_neg = 1'b0; m_err = 1'b0;
    check_all("R8");

    // R5: clean op after reset keeps halt low
    run_op(2'b00, 16'hFFFF, 16'hFFFF);
    check_all("R5");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule